// File: doc/BRIEF.md
# Indexed Event Counter Bank with Threshold Interrupts

This block is a performance-monitoring unit. It holds a small bank of wide event counters. Each counter watches one condition, chosen by number from a vector of single-cycle event pulses. A counter can be limited so that it counts only while the core runs in kernel mode, or only while it runs in user mode. Software reaches the bank through a synchronous register port. A shared index register decides which counter the per-counter registers act on.

Software can load a counter through two halves. It can capture the selected counter into a snapshot pair with one control write, so that a wide value is read without tearing. It can also set a per-counter threshold. When an interrupt-enabled counter steps onto its threshold, that counter's active flag is raised, and the single interrupt output reports any counter whose flag and enable are both set. A read-only build register tells software how many counters there are, how wide they are, and that interrupts are supported.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, the control register, every counter value, configuration, threshold, interrupt-enable bit and active bit read as zero, and `irq` is low.
- R2: The index register (address 1) selects the counter that the configuration (3), count-low/high (4/5), snapshot (6/7) and threshold-low/high (8/9) registers address. A write to these registers leaves every other counter unchanged.
- R3: Control register (address 2) bit 0 enables all counters at once; while it is 0 no counter steps. Bits 31:16 read back as written. Bits 15:1 read as zero.
- R4: Configuration bits 7:0 hold the condition number. Each cycle, a counting counter with condition k in 1..N_COND-1 adds one if `events[k]` is high. Condition 0 and conditions of N_COND or above never count.
- R5: Configuration bit 8 limits counting to cycles with `mode_kernel`=1, and bit 9 limits it to cycles with `mode_kernel`=0. With both bits clear or both set, the mode does not matter.
- R6: Count-low loads value bits 31:0 and count-high loads bits W-1:32. A load takes priority over a count step in the same cycle.
- R7: Writing control with bit 1 set copies the selected counter's value of that cycle into the snapshot registers: bits 31:0 to address 6, the upper bits to address 7. Later changes to the counter do not alter the snapshot.
- R8: A counter's active bit, read at interrupt-active (address 11) bit i, sets when that counter steps onto its threshold while its enable bit (interrupt-enable address 10, bit i) is 1. A step onto the threshold with the enable bit 0 does not set it. `irq` is high exactly when some counter has both its active and enable bits set.
- R9: Writing 1 to bit i of interrupt-active clears that counter's active bit and also clears its interrupt-enable bit.
- R10: Counters are W = 32+16·S bits wide and wrap from all ones to zero.
- R11: The build register (address 0) reads bit 0 = 1 (present), bit 1 = 1 (interrupts supported), bits 11:8 = S and bits 23:16 = number of counters. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| events | input | N_COND | Single-cycle event pulses, one per condition |
| mode_kernel | input | 1 | 1 while the core runs in kernel mode |
| irq | output | 1 | Threshold interrupt request |

## Verification
The counting path is swept over every counter, every condition number from 0 to two beyond the last real condition, and all four mode-qualifier settings. The event and mode patterns change every cycle and differ per counter. A wrong bit select, a swapped qualifier or a counter stepping on the wrong condition therefore gives a count that differs from the one the bench computes. The remaining patterns each separate one behaviour. Holding all events high while the bank is disabled separates the global enable from the condition logic. Loading a counter in a cycle with an event tells load priority from counting. Stepping across the all-ones value shows the wrap. Reaching the threshold with the enable bit set and then clear separates the active flag from the interrupt gate and from the write-one-to-clear side effect.

// File: rtl/evcnt_pkg.sv
// Package: register addresses and field positions shared by the counter bank.
// Assumes a 4-bit register address and 32-bit data words.
package evcnt_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        A_BUILD   = 4'd0,
        A_INDEX   = 4'd1,
        A_CTRL    = 4'd2,
        A_CFG     = 4'd3,
        A_CNT_LO  = 4'd4,
        A_CNT_HI  = 4'd5,
        A_SNAP_LO = 4'd6,
        A_SNAP_HI = 4'd7,
        A_THR_LO  = 4'd8,
        A_THR_HI  = 4'd9,
        A_INT_EN  = 4'd10,
        A_INT_ACT = 4'd11
    } reg_addr_e;

    // Control register fields
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SNAP_BIT = 1;

    // Configuration register fields
    localparam int CFG_W        = 10;
    localparam int CFG_KERN_BIT = 8;
    localparam int CFG_USER_BIT = 9;

endpackage

// File: rtl/evcnt_select.sv
// Module: picks the event pulse named by the condition number and applies
// the privilege-mode qualifier. Purely combinational.
// Assumes condition 0 and numbers of N_COND or above never produce a hit.
module evcnt_select #(
    parameter int N_COND = 8
) (
    input  logic [7:0]        cond,
    input  logic              kern_only,
    input  logic              user_only,
    input  logic [N_COND-1:0] events,
    input  logic              mode_kernel,
    output logic              hit
);

    logic ev_sel;
    logic mode_ok;

    // Decode the condition number into one event bit; 0 is never.
    always_comb begin
        ev_sel = 1'b0;
        for (int j = 1; j < N_COND; j++) begin
            if (cond == 8'(j)) ev_sel = events[j];
        end
    end

    // One qualifier alone restricts the mode; none or both allow any mode.
    always_comb begin
        if (kern_only && !user_only)      mode_ok = mode_kernel;
        else if (user_only && !kern_only) mode_ok = !mode_kernel;
        else                              mode_ok = 1'b1;
    end

    assign hit = ev_sel && mode_ok;

endmodule

// File: rtl/evcnt_counter.sv
// Module: one counter slice. Holds the value, configuration, threshold,
// interrupt-enable and interrupt-active state of a single counter.
// Assumes the write strobes arrive already qualified by the counter index,
// and W lies in 48..64.
module evcnt_counter
    import evcnt_pkg::*;
#(
    parameter int W      = 48,
    parameter int N_COND = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic [N_COND-1:0] events,
    input  logic              mode_kernel,
    input  logic              cfg_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              thr_lo_we,
    input  logic              thr_hi_we,
    input  logic [31:0]       wdata,
    input  logic              ien_we,
    input  logic              ien_d,
    input  logic              act_clr,
    output logic [W-1:0]      value,
    output logic [W-1:0]      thr,
    output logic [CFG_W-1:0]  cfg,
    output logic              ien,
    output logic              act
);

    localparam int HW = W - 32;

    logic         hit;
    logic         step;
    logic         val_wr;
    logic [W-1:0] nxt;
    logic         fire;

    evcnt_select #(.N_COND(N_COND)) u_sel (
        .cond        (cfg[7:0]),
        .kern_only   (cfg[CFG_KERN_BIT]),
        .user_only   (cfg[CFG_USER_BIT]),
        .events      (events),
        .mode_kernel (mode_kernel),
        .hit         (hit)
    );

    assign val_wr = lo_we || hi_we;
    assign step   = glob_en && hit && !val_wr;
    assign nxt    = value + W'(1);
    assign fire   = step && ien && (nxt == thr);

    // Counter value: a software load wins over a count step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (val_wr) begin
            if (lo_we) value[31:0]   <= wdata;
            if (hi_we) value[W-1:32] <= wdata[HW-1:0];
        end else if (step) begin
            value <= nxt;
        end
    end

    // Configuration and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            thr <= '0;
        end else begin
            if (cfg_we)    cfg           <= wdata[CFG_W-1:0];
            if (thr_lo_we) thr[31:0]     <= wdata;
            if (thr_hi_we) thr[W-1:32]   <= wdata[HW-1:0];
        end
    end

    // Interrupt enable and active flag; write-one-to-clear drops both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
            act <= 1'b0;
        end else if (act_clr) begin
            ien <= 1'b0;
            act <= 1'b0;
        end else begin
            if (ien_we) ien <= ien_d;
            if (fire)   act <= 1'b1;
        end
    end

    AST_NEVER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[7:0] == 8'd0 && !lo_we && !hi_we) |=> value == $past(value)); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !lo_we && !hi_we) |=> value == $past(value)); // R3

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_we && !hi_we) |=> (value == $past(value) || value == $past(value) + W'(1))); // R10

    AST_ACT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $past(ien)); // R8

    AST_W1C_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        act_clr |=> (!act && !ien)); // R9

endmodule

// File: rtl/evcnt_bank.sv
// Module: top of the indexed event counter bank. Decodes the register port,
// keeps the index, control and snapshot state, generates the counter slices
// and forms the interrupt.
// Assumes 1 <= SIZE_S <= 2 and N_CTR <= 32; reads are combinational.
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int N_CTR  = 4,
    parameter int SIZE_S = 1,
    parameter int N_COND = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_COND-1:0] events,
    input  logic              mode_kernel,
    output logic              irq
);

    localparam int W  = 32 + 16 * SIZE_S;
    localparam int HW = W - 32;
    localparam int IW = (N_CTR > 1) ? $clog2(N_CTR) : 1;

    logic [IW-1:0]    idx;
    logic             ctrl_en;
    logic [15:0]      ctrl_up;
    logic [W-1:0]     snap;
    logic [W-1:0]     val_arr [N_CTR];
    logic [W-1:0]     thr_arr [N_CTR];
    logic [CFG_W-1:0] cfg_arr [N_CTR];
    logic [N_CTR-1:0] ien_vec;
    logic [N_CTR-1:0] act_vec;
    logic [W-1:0]     sel_val;
    logic [W-1:0]     sel_thr;
    logic [CFG_W-1:0] sel_cfg;
    logic             snap_trig;
    reg_addr_e        addr;

    assign addr      = reg_addr_e'(reg_addr);
    assign snap_trig = reg_we && addr == A_CTRL && reg_wdata[CTRL_SNAP_BIT];

    // Index and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            ctrl_en <= 1'b0;
            ctrl_up <= '0;
        end else if (reg_we) begin
            if (addr == A_INDEX) idx <= reg_wdata[IW-1:0];
            if (addr == A_CTRL) begin
                ctrl_en <= reg_wdata[CTRL_EN_BIT];
                ctrl_up <= reg_wdata[31:16];
            end
        end
    end

    // Snapshot capture of the selected counter.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (snap_trig) snap <= sel_val;
    end

    generate
        for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
            logic sel_i;
            assign sel_i = (idx == IW'(i));

            evcnt_counter #(.W(W), .N_COND(N_COND)) u_ctr (
                .clk         (clk),
                .rst_n       (rst_n),
                .glob_en     (ctrl_en),
                .events      (events),
                .mode_kernel (mode_kernel),
                .cfg_we      (reg_we && sel_i && addr == A_CFG),
                .lo_we       (reg_we && sel_i && addr == A_CNT_LO),
                .hi_we       (reg_we && sel_i && addr == A_CNT_HI),
                .thr_lo_we   (reg_we && sel_i && addr == A_THR_LO),
                .thr_hi_we   (reg_we && sel_i && addr == A_THR_HI),
                .wdata       (reg_wdata),
                .ien_we      (reg_we && addr == A_INT_EN),
                .ien_d       (reg_wdata[i]),
                .act_clr     (reg_we && addr == A_INT_ACT && reg_wdata[i]),
                .value       (val_arr[i]),
                .thr         (thr_arr[i]),
                .cfg         (cfg_arr[i]),
                .ien         (ien_vec[i]),
                .act         (act_vec[i])
            );
        end
    endgenerate

    // Select the indexed counter's state for reads and snapshots.
    always_comb begin
        sel_val = '0;
        sel_thr = '0;
        sel_cfg = '0;
        for (int i = 0; i < N_CTR; i++) begin
            if (idx == IW'(i)) begin
                sel_val = val_arr[i];
                sel_thr = thr_arr[i];
                sel_cfg = cfg_arr[i];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_BUILD: begin
                reg_rdata[0]     = 1'b1;
                reg_rdata[1]     = 1'b1;
                reg_rdata[11:8]  = 4'(SIZE_S);
                reg_rdata[23:16] = 8'(N_CTR);
            end
            A_INDEX:   reg_rdata[IW-1:0]    = idx;
            A_CTRL: begin
                reg_rdata[CTRL_EN_BIT] = ctrl_en;
                reg_rdata[31:16]       = ctrl_up;
            end
            A_CFG:     reg_rdata[CFG_W-1:0] = sel_cfg;
            A_CNT_LO:  reg_rdata            = sel_val[31:0];
            A_CNT_HI:  reg_rdata[HW-1:0]    = sel_val[W-1:32];
            A_SNAP_LO: reg_rdata            = snap[31:0];
            A_SNAP_HI: reg_rdata[HW-1:0]    = snap[W-1:32];
            A_THR_LO:  reg_rdata            = sel_thr[31:0];
            A_THR_HI:  reg_rdata[HW-1:0]    = sel_thr[W-1:32];
            A_INT_EN:  reg_rdata[N_CTR-1:0] = ien_vec;
            A_INT_ACT: reg_rdata[N_CTR-1:0] = act_vec;
            default:   reg_rdata            = '0;
        endcase
    end

    assign irq = |(act_vec & ien_vec);

    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        snap_trig |=> snap == $past(sel_val)); // R7

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_trig |=> $stable(snap)); // R7

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (act_vec != '0)); // R8

endmodule

// File: tb/evcnt_bank_bench.sv
`timescale 1ns/1ps
module evcnt_bank_bench;

    localparam int NC = 4;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NE-1:0] events = '0;
    logic        mode_kernel = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_err = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    evcnt_bank #(.N_CTR(NC), .SIZE_S(1), .N_COND(NE)) u_evcnt_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events),
        .mode_kernel(mode_kernel), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] pat(input int i, input int c);
        return 8'((i * 37 + c * 11 + 5) ^ (i >> 1));
    endfunction

    function automatic logic mbit(input int i, input int c);
        return 1'(((i * 5 + c) >> 1) & 1);
    endfunction

    function automatic int exp_count(input int c, input int cond, input int q, input int len);
        int n = 0;
        if (cond == 0 || cond >= NE) return 0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] p = pat(i, c);
            logic m = mbit(i, c);
            logic ok = (q == 0 || q == 3) || (q == 1 && m) || (q == 2 && !m);
            if (p[cond] && ok) n++;
        end
        return n;
    endfunction

    // Drive len cycles of events: the per-counter pattern or all ones.
    task automatic burst(input int c, input int len, input bit ones);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            events = ones ? '1 : pat(i, c);
            mode_kernel = mbit(i, c);
        end
        @(negedge clk);
        events = '0;
        mode_kernel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd2, rv);  check("R1 ctrl", rv, 32'h0);
        rd(4'd10, rv); check("R1 int_en", rv, 32'h0);
        rd(4'd11, rv); check("R1 int_act", rv, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        for (int c = 0; c < NC; c++) begin
            wr(4'd1, c);
            rd(4'd4, rv); check("R1 count_lo", rv, 32'h0);
            rd(4'd3, rv); check("R1 cfg", rv, 32'h0);
            rd(4'd8, rv); check("R1 thr_lo", rv, 32'h0);
        end

        // R11: build register
        rd(4'd0, rv); check("R11 build", rv, 32'h0004_0103);

        // R2: index selects, writes stay local
        for (int c = 0; c < NC; c++) begin
            wr(4'd1, c); wr(4'd4, 32'h100 + c);
        end
        for (int c = 0; c < NC; c++) begin
            wr(4'd1, c); rd(4'd4, rv); check("R2 indexed value", rv, 32'h100 + c);
        end

        // R4 R5: sweep counters, conditions and qualifiers
        wr(4'd2, 32'h1);
        for (int c = 0; c < NC; c++) begin
            for (int cond = 0; cond < NE + 2; cond++) begin
                for (int q = 0; q < 4; q++) begin
                    wr(4'd1, c);
                    wr(4'd3, (q << 8) | cond);
                    wr(4'd4, 0); wr(4'd5, 0);
                    burst(c, 20, 1'b0);
                    rd(4'd4, rv);
                    check("R4 R5 count", rv, exp_count(c, cond, q, 20));
                end
            end
        end

        // R3: global disable, control readback
        wr(4'd2, 32'h00AB_0000);
        wr(4'd1, 0); wr(4'd3, 1); wr(4'd4, 0); wr(4'd5, 0);
        burst(0, 4, 1'b1);
        rd(4'd4, rv); check("R3 disabled count", rv, 32'h0);
        rd(4'd2, rv); check("R3 ctrl readback", rv, 32'h00AB_0000);
        wr(4'd2, 32'h00AB_0003);
        rd(4'd2, rv); check("R3 ctrl snap bit reads 0", rv, 32'h00AB_0001);

        // R6: load wins over a step in the same cycle
        wr(4'd5, 7);
        @(negedge clk); events = '1;
        wr(4'd4, 100);
        events = '0;
        rd(4'd4, rv); check("R6 load priority lo", rv, 32'd100);
        rd(4'd5, rv); check("R6 hi kept", rv, 32'd7);

        // R10: wrap at 2^48
        wr(4'd1, 1); wr(4'd3, 1);
        wr(4'd4, 32'hFFFF_FFFE); wr(4'd5, 32'h0000_FFFF);
        burst(1, 3, 1'b1);
        rd(4'd4, rv); check("R10 wrap lo", rv, 32'h1);
        rd(4'd5, rv); check("R10 wrap hi", rv, 32'h0);

        // R7: snapshot
        wr(4'd2, 32'h0);
        wr(4'd1, 3); wr(4'd4, 32'h89AB_CDEF); wr(4'd5, 32'h1234);
        wr(4'd2, 32'h2);
        wr(4'd4, 32'h0); wr(4'd5, 32'h0);
        rd(4'd6, rv); check("R7 snap lo", rv, 32'h89AB_CDEF);
        rd(4'd7, rv); check("R7 snap hi", rv, 32'h1234);
        rd(4'd4, rv); check("R7 live after change", rv, 32'h0);

        // R8: no active bit without enable
        wr(4'd2, 32'h1);
        wr(4'd1, 1); wr(4'd3, 1); wr(4'd8, 3); wr(4'd9, 0);
        wr(4'd4, 0); wr(4'd5, 0);
        burst(1, 5, 1'b1);
        rd(4'd11, rv); check("R8 no enable no active", rv, 32'h0);

        // R8: threshold reached with enable
        wr(4'd1, 2); wr(4'd3, 1); wr(4'd8, 10); wr(4'd9, 0);
        wr(4'd4, 5); wr(4'd5, 0);
        wr(4'd10, 32'h4);
        burst(2, 3, 1'b1);
        rd(4'd11, rv); check("R8 below threshold", rv, 32'h0);
        check("R8 irq low below", {31'd0, irq}, 32'h0);
        burst(2, 2, 1'b1);
        rd(4'd11, rv); check("R8 active set", rv, 32'h4);
        check("R8 irq high", {31'd0, irq}, 32'h1);
        wr(4'd10, 32'h0);
        check("R8 irq gated by enable", {31'd0, irq}, 32'h0);
        rd(4'd11, rv); check("R8 active kept", rv, 32'h4);
        wr(4'd10, 32'h4);
        check("R8 irq restored", {31'd0, irq}, 32'h1);

        // R9: write-one-to-clear also drops enable
        wr(4'd11, 32'h4);
        rd(4'd11, rv); check("R9 active cleared", rv, 32'h0);
        rd(4'd10, rv); check("R9 enable cleared", rv, 32'h0);
        check("R9 irq low", {31'd0, irq}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule